// File: doc/BRIEF.md
# GPIO Bank With Edge Interrupts

This block controls 32 general-purpose pins from a simple 32-bit register bus. Each pin has a direction bit. A pin set as an output drives the value held in its output latch. Software changes the latch by writing masks to a set port and a clear port, so a single write changes individual bits and no read-modify-write is needed. Pin levels pass through a two-flop synchronizer. Software can read them back whether the pin is an input or an output.

Each pin can flag rising edges, falling edges or both. The two enables are also changed through their own set and clear ports. A detected edge latches into a status register, and software clears a status bit by writing 1 to it. The pins form two interrupt banks of 16 pins each. Each bank drives one interrupt line, and a bank-enable register gates that line. Because each line follows the OR of its bank's status bits, the line stays high until software clears the bits behind it.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Direction register (offset 0x10): bit value 1 makes the pin an input, with `pin_oe` low. Bit value 0 makes it an output, with `pin_oe` high and `pin_out` carrying the latch bit. After reset the register reads all ones.
- R2: A write to the set-output port (0x18) sets the latch bits where the data is 1. A write to the clear-output port (0x1C) clears them. Bits written as 0 keep their value. The latch reads back at 0x14 and drives `pin_out` from the cycle after the write. Writes to the read-only offsets 0x14 and 0x20 change nothing.
- R3: The input-data register (0x20) returns `pin_in`, whatever the direction. A level change becomes visible exactly two clock edges after it is applied, so a read right after a change still returns the old level.
- R4: Rising-edge detection has a set port (0x28), a clear port (0x2C) and a readback (0x24). Falling-edge detection has a set port (0x34), a clear port (0x38) and a readback (0x30). Both use write-one semantics and keep the bits written as 0.
- R5: A 0-to-1 change on a pin with rising detection enabled sets its status bit three clock edges after the change is applied. A 1-to-0 change does the same for a pin with falling detection enabled. A change in a direction that is not enabled leaves the status unchanged.
- R6: The status register (0x3C) is cleared by writing 1 to a bit, and bits written as 0 keep their value. If an edge and a clear reach the same bit at the same clock edge, the edge wins and the bit stays 1.
- R7: The bank-enable register (0x08) holds 5 bits, with bits 31:5 reading 0. `irq[0]` is high while bank-enable bit 0 is 1 and any status bit in 15:0 is set. `irq[1]` is high while bank-enable bit 1 is 1 and any status bit in 31:16 is set.
- R8: After reset the output latch, both edge enables, the status register, the bank enables, `pin_oe` and `irq` are all zero.
- R9: The latch can be loaded while the pin is still an input. When the direction bit then clears, `pin_oe` rises in the same cycle that `pin_out` already holds the new value, so the pin never drives a stale level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |
| irq | output | 2 | Interrupt per 16-pin bank |

## Verification
Register writes take effect at the clock edge that samples the strobe, and read data is combinational. The bench therefore reads every register and port at the falling edge that follows the write. A pin change applied at a falling edge becomes readable at the input-data offset two falling edges later. Its status bit and the interrupt line that follows it are due three falling edges later. The bench checks both the cycle before each of these results is due and the cycle it arrives. In the edge-versus-clear case the clear strobe is placed in the cycle whose closing edge also latches the edge.

// File: rtl/gpio_edge_pkg.sv
// Package: register offsets shared by the register file, the checker and
// anyone decoding this block's address space. Offsets are byte addresses.
package gpio_edge_pkg;
    localparam int unsigned OFF_BANK_EN  = 'h08;
    localparam int unsigned OFF_DIR      = 'h10;
    localparam int unsigned OFF_OUT      = 'h14;
    localparam int unsigned OFF_SET_OUT  = 'h18;
    localparam int unsigned OFF_CLR_OUT  = 'h1C;
    localparam int unsigned OFF_IN       = 'h20;
    localparam int unsigned OFF_RISE     = 'h24;
    localparam int unsigned OFF_SET_RISE = 'h28;
    localparam int unsigned OFF_CLR_RISE = 'h2C;
    localparam int unsigned OFF_FALL     = 'h30;
    localparam int unsigned OFF_SET_FALL = 'h34;
    localparam int unsigned OFF_CLR_FALL = 'h38;
    localparam int unsigned OFF_STATUS   = 'h3C;
endpackage

// File: rtl/gpio_edge_sync.sv
// Module: two-flop synchronizer plus one history stage per pin.
// Assumes pin_in is asynchronous to clk. lvl is the synchronized level and
// prv is lvl delayed by one cycle; their difference marks an edge.
module gpio_edge_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta;

    // Shift pin levels through the metastability stage, sync stage and history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            lvl  <= '0;
            prv  <= '0;
        end else begin
            meta <= pin_in;
            lvl  <= meta;
            prv  <= lvl;
        end
    end
endmodule

// File: rtl/gpio_edge_det.sv
// Module: per-pin edge detection and write-one-to-clear status latch.
// Assumes lvl/prv come from gpio_edge_sync. A fresh edge overrides a clear
// that targets the same bit in the same cycle.
module gpio_edge_det #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] prv,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    logic [W-1:0] hit;

    // Edge hits in the enabled direction only.
    always_comb begin
        hit = (lvl & ~prv & rise_en) | (~lvl & prv & fall_en);
    end

    // Status: clear requested bits, then OR in new hits so edges win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_mask) | hit;
        end
    end
endmodule

// File: rtl/gpio_edge_regs.sv
// Module: register file and read mux. Assumes one bus word per cycle, with
// word-aligned addresses; unaligned or unmapped offsets read 0, write nothing.
module gpio_edge_regs #(
    parameter int unsigned NPINS    = 32,
    parameter int unsigned NBANK_EN = 5,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NPINS-1:0]    bus_wdata,
    input  logic [NPINS-1:0]    in_lvl,
    input  logic [NPINS-1:0]    status,
    output logic [NPINS-1:0]    bus_rdata,
    output logic [NPINS-1:0]    dir,
    output logic [NPINS-1:0]    out_lat,
    output logic [NPINS-1:0]    rise_en,
    output logic [NPINS-1:0]    fall_en,
    output logic [NBANK_EN-1:0] bank_en,
    output logic [NPINS-1:0]    stat_clr
);
    import gpio_edge_pkg::*;

    localparam logic [ADDR_W-1:0] A_BEN  = ADDR_W'(OFF_BANK_EN);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFF_OUT);
    localparam logic [ADDR_W-1:0] A_SO   = ADDR_W'(OFF_SET_OUT);
    localparam logic [ADDR_W-1:0] A_CO   = ADDR_W'(OFF_CLR_OUT);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFF_IN);
    localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(OFF_RISE);
    localparam logic [ADDR_W-1:0] A_SR   = ADDR_W'(OFF_SET_RISE);
    localparam logic [ADDR_W-1:0] A_CR   = ADDR_W'(OFF_CLR_RISE);
    localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(OFF_FALL);
    localparam logic [ADDR_W-1:0] A_SF   = ADDR_W'(OFF_SET_FALL);
    localparam logic [ADDR_W-1:0] A_CF   = ADDR_W'(OFF_CLR_FALL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STATUS);

    logic [NPINS-1:0] m_so, m_co, m_sr, m_cr, m_sf, m_cf;

    // Write masks: write data where the strobe hits that port, else zero.
    always_comb begin
        m_so     = (bus_we && bus_addr == A_SO)   ? bus_wdata : '0;
        m_co     = (bus_we && bus_addr == A_CO)   ? bus_wdata : '0;
        m_sr     = (bus_we && bus_addr == A_SR)   ? bus_wdata : '0;
        m_cr     = (bus_we && bus_addr == A_CR)   ? bus_wdata : '0;
        m_sf     = (bus_we && bus_addr == A_SF)   ? bus_wdata : '0;
        m_cf     = (bus_we && bus_addr == A_CF)   ? bus_wdata : '0;
        stat_clr = (bus_we && bus_addr == A_STAT) ? bus_wdata : '0;
    end

    // Direction and bank enables: plain writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir     <= '1;
            bank_en <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_DIR) dir     <= bus_wdata;
            if (bus_addr == A_BEN) bank_en <= bus_wdata[NBANK_EN-1:0];
        end
    end

    // Output latch and edge enables: set and clear through separate ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_lat <= '0;
            rise_en <= '0;
            fall_en <= '0;
        end else begin
            out_lat <= (out_lat | m_so) & ~m_co;
            rise_en <= (rise_en | m_sr) & ~m_cr;
            fall_en <= (fall_en | m_sf) & ~m_cf;
        end
    end

    // Read mux: readable registers by offset, write-only ports read zero.
    always_comb begin
        case (bus_addr)
            A_BEN:   bus_rdata = {{(NPINS-NBANK_EN){1'b0}}, bank_en};
            A_DIR:   bus_rdata = dir;
            A_OUT:   bus_rdata = out_lat;
            A_IN:    bus_rdata = in_lvl;
            A_RISE:  bus_rdata = rise_en;
            A_FALL:  bus_rdata = fall_en;
            A_STAT:  bus_rdata = status;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Module: top of the GPIO bank. Wires the register file, synchronizer and
// edge detector, and forms one gated interrupt per bank of BANK_W pins.
// Assumes NPINS is a multiple of BANK_W and NBANK_EN >= NPINS/BANK_W.
module gpio_edge_ctrl #(
    parameter int unsigned NPINS    = 32,
    parameter int unsigned BANK_W   = 16,
    parameter int unsigned NBANK_EN = 5,
    parameter int unsigned ADDR_W   = 6,
    localparam int unsigned NBANKS  = NPINS / BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NBANKS-1:0] irq
);
    logic [NPINS-1:0]    lvl, prv, dir, out_lat, rise_en, fall_en, stat_clr, status_q;
    logic [NBANK_EN-1:0] bank_en;

    gpio_edge_regs #(.NPINS(NPINS), .NBANK_EN(NBANK_EN), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .in_lvl(lvl), .status(status_q),
        .bus_rdata(bus_rdata), .dir(dir), .out_lat(out_lat),
        .rise_en(rise_en), .fall_en(fall_en), .bank_en(bank_en),
        .stat_clr(stat_clr)
    );

    gpio_edge_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvl(lvl), .prv(prv)
    );

    gpio_edge_det #(.W(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .prv(prv),
        .rise_en(rise_en), .fall_en(fall_en), .clr_mask(stat_clr),
        .status(status_q)
    );

    // Pin drive: output enable is the inverse of the input-direction bit.
    always_comb begin
        pin_out = out_lat;
        pin_oe  = ~dir;
    end

    // One interrupt per bank: gated OR of that bank's status slice.
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign irq[b] = bank_en[b] & (|status_q[b*BANK_W +: BANK_W]);
    end
endmodule

// File: rtl/gpio_edge_chk.sv
// Module: checker bound to gpio_edge_ctrl. Watches bus writes, pin outputs,
// status and interrupt lines; it drives nothing.
module gpio_edge_chk #(
    parameter int unsigned NPINS    = 32,
    parameter int unsigned NBANKS   = 2,
    parameter int unsigned NBANK_EN = 5,
    parameter int unsigned ADDR_W   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NPINS-1:0]    bus_wdata,
    input logic [NPINS-1:0]    pin_out,
    input logic [NPINS-1:0]    status_q,
    input logic [NPINS-1:0]    rise_en,
    input logic [NPINS-1:0]    fall_en,
    input logic [NBANK_EN-1:0] bank_en,
    input logic [NBANKS-1:0]   irq
);
    import gpio_edge_pkg::*;

    // R2: set port forces the written ones high on the next cycle.
    p_set_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_SET_OUT))
        |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    // R2: clear port forces the written ones low on the next cycle.
    p_clr_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_CLR_OUT))
        |=> ((pin_out & $past(bus_wdata)) == '0));

    // R6: without a status clear, no status bit falls.
    p_hold_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_W'(OFF_STATUS))
        |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R5: a new status bit needs an edge enable on that pin.
    p_new_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q)
                   & ~($past(rise_en) | $past(fall_en))) == '0));

    // R7: no interrupt while all status bits are clear.
    p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> (irq == '0));

    for (genvar b = 0; b < NBANKS; b++) begin : g_chk
        // R7: a bank interrupt implies its enable bit.
        p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
            irq[b] |-> bank_en[b]);
    end
endmodule

bind gpio_edge_ctrl gpio_edge_chk #(
    .NPINS(NPINS), .NBANKS(NBANKS), .NBANK_EN(NBANK_EN), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pin_out(pin_out), .status_q(status_q),
    .rise_en(rise_en), .fall_en(fall_en), .bank_en(bank_en), .irq(irq)
);

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_we = 0;
    logic [5:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = 0;
    logic [31:0] pin_out, pin_oe;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_dir, m_out, m_rise, m_fall, m_stat, m_pin;
    logic [4:0]  m_ben;

    always #5 clk = ~clk;

    gpio_edge_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [1:0] exp_irq();
        return {m_ben[1] & (|m_stat[31:16]), m_ben[0] & (|m_stat[15:0])};
    endfunction

    // Compare every readable register and output against the model.
    task automatic verify_all(input string ctx);
        logic [31:0] v;
        rd('h10, v); chk({ctx, " R1 dir"}, v, m_dir);
        chk({ctx, " R1 pin_oe"}, pin_oe, ~m_dir);
        rd('h14, v); chk({ctx, " R2 out"}, v, m_out);
        chk({ctx, " R2 pin_out"}, pin_out, m_out);
        rd('h20, v); chk({ctx, " R3 in"}, v, m_pin);
        rd('h24, v); chk({ctx, " R4 rise"}, v, m_rise);
        rd('h30, v); chk({ctx, " R4 fall"}, v, m_fall);
        rd('h3C, v); chk({ctx, " R6 status"}, v, m_stat);
        rd('h08, v); chk({ctx, " R7 bank_en"}, v, {27'd0, m_ben});
        chk({ctx, " R7 irq"}, {30'd0, irq}, {30'd0, exp_irq()});
    endtask

    // Apply a pin change and wait until its status effect is due (3 edges).
    task automatic pins(input logic [31:0] nv);
        @(negedge clk);
        pin_in = nv;
        repeat (3) @(negedge clk);
        m_stat = m_stat | (m_rise & ~m_pin & nv) | (m_fall & m_pin & ~nv);
        m_pin  = nv;
    endtask

    initial begin
        #(10 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, d;
        void'($urandom(32'd7341));
        m_dir = '1; m_out = 0; m_rise = 0; m_fall = 0; m_stat = 0; m_pin = 0; m_ben = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        verify_all("reset R8");

        // R3: level visible two edges after change, not one.
        @(negedge clk); pin_in = 32'h0000_0081;
        @(negedge clk); rd('h20, v); chk("R3 one edge old", v, 32'h0);
        @(negedge clk); rd('h20, v); chk("R3 two edges new", v, 32'h0000_0081);
        m_pin = 32'h0000_0081;

        // R5: rising edge on pin 20 sets status at third edge, irq gated by R7.
        wr('h28, 32'h0010_0000); m_rise = 32'h0010_0000;
        wr('h08, 32'hFFFF_FFFF); m_ben = 5'h1F;
        @(negedge clk); pin_in = m_pin | 32'h0010_0000;
        repeat (2) @(negedge clk);
        rd('h3C, v); chk("R5 status not yet", v, 32'h0);
        @(negedge clk);
        rd('h3C, v); chk("R5 status set", v, 32'h0010_0000);
        chk("R7 irq odd bank", {30'd0, irq}, 32'h2);
        m_pin = pin_in; m_stat = 32'h0010_0000;
        wr('h08, 32'h1); m_ben = 5'h01;
        chk("R7 irq gated off", {30'd0, irq}, 32'h0);
        wr('h3C, 32'h0010_0000); m_stat = 0;
        verify_all("R6 clear");

        // R6: edge and clear at the same clock edge on pin 3: edge wins.
        wr('h28, 32'h8); wr('h34, 32'h8);
        m_rise = m_rise | 32'h8; m_fall = 32'h8;
        pins(m_pin | 32'h8);
        rd('h3C, v); chk("R6 rise latched", v, 32'h8);
        chk("R7 irq even bank", {30'd0, irq}, 32'h1);
        @(negedge clk); pin_in = m_pin & ~32'h8;
        @(negedge clk);
        @(negedge clk); bus_we = 1; bus_addr = 'h3C; bus_wdata = 32'h8;
        @(negedge clk); bus_we = 0;
        m_pin = pin_in;
        rd('h3C, v); chk("R6 edge wins over clear", v, 32'h8);
        wr('h3C, 32'h8); m_stat = 0;
        rd('h3C, v); chk("R6 plain clear", v, 32'h0);

        // R9: load latch while input, then switch to output.
        wr('h18, 32'h0000_4000); m_out = m_out | 32'h0000_4000;
        chk("R9 still input", pin_oe & 32'h4000, 32'h0);
        chk("R9 latch preloaded", pin_out & 32'h4000, 32'h4000);
        wr('h10, ~32'h0000_4000); m_dir = ~32'h0000_4000;
        chk("R9 drive with new value", pin_oe & pin_out & 32'h4000, 32'h4000);

        // R2: writes to read-only offsets change nothing.
        wr('h14, 32'hFFFF_FFFF); wr('h20, 32'hFFFF_FFFF);
        verify_all("R2 readonly");

        // Random mix of port writes and pin changes against the model.
        for (int i = 0; i < 400; i++) begin
            d = $urandom;
            case ($urandom % 12)
                0: begin wr('h18, d); m_out = m_out | d; end
                1: begin wr('h1C, d); m_out = m_out & ~d; end
                2: begin wr('h10, d); m_dir = d; end
                3: begin wr('h28, d); m_rise = m_rise | d; end
                4: begin wr('h2C, d); m_rise = m_rise & ~d; end
                5: begin wr('h34, d); m_fall = m_fall | d; end
                6: begin wr('h38, d); m_fall = m_fall & ~d; end
                7: begin wr('h3C, d); m_stat = m_stat & ~d; end
                8: begin wr('h08, d); m_ben = d[4:0]; end
                default: pins(m_pin ^ (d & $urandom));
            endcase
            if (i % 4 == 0) verify_all("random R4 R5 R6");
        end
        verify_all("final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule